// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog peripheral for a system-on-chip. A 16-bit down-counter advances once per tick. The tick comes from the peripheral clock through two divider stages: a programmable prescaler that divides by its field value plus one, then a power-of-two stage that divides by 16, 32, 64 or 128. If the counter runs out while the timer is running and allowed to reset, the block emits a one-clock system reset pulse. Software services the watchdog by writing the count register before that happens.

Three registers sit behind a plain word-wide write/read strobe port: a control word, a reload word and the live count. A timeout of N ticks is set by loading N-1. The reload word can only be changed while the timer is fully switched off. When the counter reaches zero it takes the reload value and carries on counting, whether or not a reset is raised.

Top module: `wdog_timer`

## Requirements
- R1: After synchronous reset the control word reads 0x0000, the reload and count words read 0xFFFF, and the reset pulse output is low.
- R2: Control word layout: bit 0 reset-enable, bit 5 run-enable, bits 4:3 divider select, bits 15:8 prescale field. All other bits read back as zero. Register addresses are control 0, reload 1, count 2.
- R3: While run-enable is set, one tick occurs every (prescale+1) * 2^(4+select) clock cycles. No ticks occur while run-enable is clear.
- R4: With the count and reload words holding N-1, the reset pulse is high in the cycle that follows the N*(prescale+1)*2^(4+select)-th rising edge after the control write that sets both enables.
- R5: A write to the count word loads the written value in the same edge and restarts both divider stages. The next timeout is therefore a full N ticks from the write.
- R6: A write to the reload word is ignored while run-enable or reset-enable is set. It takes effect when both are clear.
- R7: On a tick with the count at zero, the count reloads from the reload word. If reset-enable is clear, no pulse is produced.
- R8: Clearing run-enable stops counting at once. The count holds its value and no pulse is produced.
- R9: Starting from a default-reset prescaler and select, the sequence control=0, count=1, control=run|reset-enable produces the pulse 32 cycles after the last write.
- R10: The reset pulse is exactly one clock wide and is produced only when both enables were set at expiry.
- R11: A read strobe returns the addressed word on reg_rdata after the next rising edge. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 2 | Register address (0 control, 1 reload, 2 count) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| wdt_rst_pulse | output | 1 | One-cycle system reset request |

## Verification
The bench measures the exact cycle distance from enable to pulse across every divider select and across prescale extremes. A design that dropped the plus-one on the prescaler, or that shifted by the wrong base, would miss these counts by a whole factor. It kicks the count mid-period and expects a full timeout from the kick, which exposes a divider chain that keeps its old phase. It also writes the reload word with only one enable bit set, expecting the write to be dropped. Finally, it runs with reset-enable clear and expects the counter to wrap to the reload value without a pulse, which catches a pulse gated only on expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 2;
  localparam int PRE_W      = 8;
  localparam int SEL_W      = 2;

  // control word bit positions
  localparam int RSTEN_BIT  = 0;
  localparam int SEL_LSB    = 3;
  localparam int RUN_BIT    = 5;
  localparam int PRE_LSB    = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             run;
    logic             rst_en;
    logic [SEL_W-1:0] sel;
    logic [PRE_W-1:0] pre;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
    ctrl_t c;
    c.run    = w[RUN_BIT];
    c.rst_en = w[RSTEN_BIT];
    c.sel    = w[SEL_LSB +: SEL_W];
    c.pre    = w[PRE_LSB +: PRE_W];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
    logic [DATA_W-1:0] w;
    w                    = '0;
    w[RUN_BIT]           = c.run;
    w[RSTEN_BIT]         = c.rst_en;
    w[SEL_LSB +: SEL_W]  = c.sel;
    w[PRE_LSB +: PRE_W]  = c.pre;
    return w;
  endfunction

endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [CNT_W-1:0]     cnt_i,
  output ctrl_t                ctrl_o,
  output logic [CNT_W-1:0]     reload_o,
  output logic                 kick_o,
  output logic [DATA_W-1:0]    rdata_o
);

  ctrl_t              ctrl_q;
  logic [CNT_W-1:0]   reload_q;
  logic [DATA_W-1:0]  rd_mux;
  logic               reload_open;
  reg_sel_e           sel_reg;

  assign sel_reg     = reg_sel_e'(addr);
  assign reload_open = !ctrl_q.run && !ctrl_q.rst_en;
  assign kick_o      = wr && (sel_reg == REG_COUNT);

  always_comb begin
    rd_mux = '0;
    case (sel_reg)
      REG_CTRL:   rd_mux = ctrl_pack(ctrl_q);
      REG_RELOAD: rd_mux = DATA_W'(reload_q);
      REG_COUNT:  rd_mux = DATA_W'(cnt_i);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '1;
      rdata_o  <= '0;
    end else begin
      if (wr && sel_reg == REG_CTRL)
        ctrl_q <= ctrl_unpack(wdata);
      if (wr && sel_reg == REG_RELOAD && reload_open)
        reload_q <= wdata[CNT_W-1:0];
      if (rd)
        rdata_o <= rd_mux;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;

endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int PRE_W      = 8,
  parameter int SEL_W      = 2,
  parameter int BASE_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre_div,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int NSEL  = 1 << SEL_W;
  localparam int DIV_W = BASE_SHIFT + NSEL - 1;

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim_tab [NSEL];
  logic             pre_hit;
  logic             div_hit;
  logic             clr;

  genvar g;
  generate
    for (g = 0; g < NSEL; g++) begin : g_lim
      assign lim_tab[g] = DIV_W'((64'd1 << (BASE_SHIFT + g)) - 64'd1);
    end
  endgenerate

  assign clr     = !run || restart;
  assign pre_hit = run && (pre_q == pre_div);
  assign div_hit = (div_q == lim_tab[sel]);
  assign tick    = pre_hit && div_hit;

  always_ff @(posedge clk) begin
    if (rst || clr)
      pre_q <= '0;
    else if (pre_hit)
      pre_q <= '0;
    else
      pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      div_q <= '0;
    else if (pre_hit)
      div_q <= div_hit ? '0 : div_q + 1'b1;
  end

endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             arm,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             pulse
);

  logic at_zero;
  assign at_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '1;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (load) begin
        cnt <= load_val;
      end else if (run && tick) begin
        if (at_zero) begin
          cnt   <= reload;
          pulse <= arm;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int BASE_SHIFT = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        wdt_rst_pulse
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             kick;
  logic             tick;
  logic             ctrl_en;
  logic             ctrl_rst_en;

  assign ctrl_en     = ctrl_q.run;
  assign ctrl_rst_en = ctrl_q.rst_en;

  wdt_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .cnt_i    (cnt_q),
    .ctrl_o   (ctrl_q),
    .reload_o (reload_q),
    .kick_o   (kick),
    .rdata_o  (reg_rdata)
  );

  wdt_tick_gen #(
    .PRE_W      (PRE_W),
    .SEL_W      (SEL_W),
    .BASE_SHIFT (BASE_SHIFT)
  ) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_en),
    .restart (kick),
    .pre_div (ctrl_q.pre),
    .sel     (ctrl_q.sel),
    .tick    (tick)
  );

  wdt_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run      (ctrl_en),
    .arm      (ctrl_rst_en),
    .tick     (tick),
    .load     (kick),
    .load_val (reg_wdata[CNT_W-1:0]),
    .reload   (reload_q),
    .cnt      (cnt_q),
    .pulse    (wdt_rst_pulse)
  );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [15:0]      reg_wdata,
  input logic             wdt_rst_pulse,
  input logic             en,
  input logic             rst_en,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload
);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_pulse |=> !wdt_rst_pulse); // R10

  AST_PULSE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_pulse |-> $past(en && rst_en)); // R10

  AST_RELOAD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    $past(reg_wr && reg_addr == 2'd1 && (en || rst_en)) |-> $stable(reload)); // R6

  AST_KICK_LOADS: assert property (@(posedge clk) disable iff (rst)
    $past(reg_wr && reg_addr == 2'd2) |-> cnt == $past(reg_wdata[CNT_W-1:0])); // R5

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(!en && !(reg_wr && reg_addr == 2'd2)) |-> ($stable(cnt) && !wdt_rst_pulse)); // R8

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    $past(tick && cnt == '0 && !(reg_wr && reg_addr == 2'd2)) |-> cnt == $past(reload)); // R7

  AST_TICK_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
    tick |-> en); // R3

endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .wdt_rst_pulse (wdt_rst_pulse),
  .en            (ctrl_en),
  .rst_en        (ctrl_rst_en),
  .tick          (tick),
  .cnt           (cnt_q),
  .reload        (reload_q)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        wdt_rst_pulse;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .wdt_rst_pulse (wdt_rst_pulse)
  );

  typedef struct packed {
    logic [7:0]  pre;
    logic [1:0]  sel;
    logic [15:0] nticks;
    logic [31:0] cycles;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{8'd0,   2'd0, 16'd3, 32'd48},
    '{8'd1,   2'd0, 16'd2, 32'd64},
    '{8'd0,   2'd1, 16'd2, 32'd64},
    '{8'd2,   2'd2, 16'd1, 32'd192},
    '{8'd0,   2'd3, 16'd2, 32'd256},
    '{8'd255, 2'd0, 16'd1, 32'd4096},
    '{8'd3,   2'd1, 16'd4, 32'd512}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // counts edges until the pulse is seen; returns -1 if none within limit
  task automatic wait_pulse(input int limit, output int k);
    k = 0;
    while (!wdt_rst_pulse && k < limit) begin
      @(negedge clk);
      k++;
    end
    if (!wdt_rst_pulse) k = -1;
  endtask

  task automatic quiet(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdt_rst_pulse) seen++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int k;
    int s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R11 reset state and read path
    check("R1 pulse low", 32'(wdt_rst_pulse), 32'd0);
    rd(2'd0, v); check("R1 ctrl", 32'(v), 32'h0000);
    rd(2'd1, v); check("R1 reload", 32'(v), 32'hFFFF);
    rd(2'd2, v); check("R1 count", 32'(v), 32'hFFFF);
    rd(2'd3, v); check("R11 unused addr", 32'(v), 32'h0000);

    // R2 field layout
    wr(2'd0, 16'hAB1E);
    rd(2'd0, v); check("R2 ctrl readback", 32'(v), 32'hAB18);
    wr(2'd0, 16'h0000);

    // R3 R4 R10 vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, 16'h0000);
      wr(2'd1, VEC[i].nticks - 16'd1);
      wr(2'd2, VEC[i].nticks - 16'd1);
      wr(2'd0, {VEC[i].pre, 2'b00, 1'b1, VEC[i].sel, 2'b00, 1'b1});
      wait_pulse(20000, k);
      check($sformatf("R4 R3 timeout vec%0d", i), 32'(k), VEC[i].cycles);
      @(negedge clk);
      check($sformatf("R10 width vec%0d", i), 32'(wdt_rst_pulse), 32'd0);
      wr(2'd0, 16'h0000);
    end

    // R5 kick restarts full period
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h0021);
    quiet(40, s);
    check("R5 no early pulse", 32'(s), 32'd0);
    wr(2'd2, 16'd3);
    wait_pulse(1000, k);
    check("R5 timeout after kick", 32'(k), 32'd64);
    wr(2'd0, 16'h0000);

    // R7 wrap without reset-enable
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h0020);
    repeat (20) @(negedge clk);
    rd(2'd2, v); check("R7 reload on zero", 32'(v), 32'd2);
    quiet(300, s);
    check("R7 no pulse without reset-enable", 32'(s), 32'd0);

    // R6 reload locked while run-enable only
    wr(2'd1, 16'h4321);
    rd(2'd1, v); check("R6 locked by run", 32'(v), 32'd2);
    wr(2'd0, 16'h0000);

    // R6 / R8 reset-enable only: no counting, reload locked
    wr(2'd2, 16'd5);
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'h1234);
    rd(2'd1, v); check("R6 locked by reset-enable", 32'(v), 32'd2);
    quiet(100, s);
    rd(2'd2, v); check("R8 no count when run clear", 32'(v), 32'd5);
    check("R8 no pulse when run clear", 32'(s), 32'd0);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0055);
    rd(2'd1, v); check("R6 accepted when off", 32'(v), 32'h0055);

    // R8 stop before expiry
    wr(2'd2, 16'd1);
    wr(2'd0, 16'h0021);
    repeat (10) @(negedge clk);
    wr(2'd0, 16'h0000);
    quiet(200, s);
    check("R8 stopped no pulse", 32'(s), 32'd0);
    rd(2'd2, v); check("R8 count held", 32'(v), 32'd1);

    // R9 forced reset sequence
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'd1);
    wr(2'd0, 16'h0021);
    wait_pulse(1000, k);
    check("R9 forced reset", 32'(k), 32'd32);
    @(negedge clk);
    check("R10 forced width", 32'(wdt_rst_pulse), 32'd0);
    wr(2'd0, 16'h0000);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule